// File: doc/BRIEF.md
# Supply and External Reset Sequencer

This block sequences the system reset of a supervisory circuit. It watches a supply-good flag from an analog comparator, which is already synchronized to the system clock. It also watches a watchdog timeout request and the two reset pins. Each pin is modelled as a sense input together with a drive enable. One pin is active high and the other is active low. When the block drives a pin, it forces that pin to its active level. When it releases a pin, the pin goes back to its inactive level through an external pull device. The block never drives the inactive level itself.

Every reset cause is stretched into a timeout of exactly `TIMEOUT_CYC` clock cycles. The causes are:
- a low supply,
- the watchdog request,
- an external level on either pin that lasts long enough to pass the glitch filter.

A state machine holds the sequence in three states:
- `ST_SUPPLY_LOW`: the supply is below threshold and the outputs are driven.
- `ST_HOLD`: the timeout is running and the outputs are driven.
- `ST_RUN`: the pins are released.

The transitions are:
- Any state goes to `ST_SUPPLY_LOW` on a low supply (supply drop).
- `ST_SUPPLY_LOW` goes to `ST_HOLD` when the supply becomes good (supply good).
- `ST_HOLD` goes back to `ST_HOLD` on a watchdog request, which restarts the timeout (restart).
- `ST_HOLD` goes to `ST_RUN` when the timeout expires (expire).
- `ST_RUN` goes to `ST_HOLD` on a watchdog request or a qualified external level (cause).

While the block drives the pins, their sense inputs are masked so that its own drive cannot be mistaken for an external reset.

Top module: `supply_reset_sequencer`

## Requirements
- R1: While `supply_ok` is 0, `reset_active`, `rst_hi_drive` and `rst_lo_drive` are all 1 from the next clock edge onward.
- R2: When `supply_ok` goes from 0 to 1, the reset stays active for exactly `TIMEOUT_CYC` cycles after the edge that samples the good supply. It is then released.
- R3: If `supply_ok` falls to 0 while the reset is released, `reset_active` is 1 one clock edge later.
- R4: `rst_hi_drive` and `rst_lo_drive` both equal `reset_active` at all times. When the reset is released, both are 0, so the pins are left to their pull devices.
- R5: An external active level lasting N ≥ `GLITCH_CYC` consecutive sampled cycles starts a reset. The active level is 1 on `rst_hi_sense` or 0 on `rst_lo_sense_n`. The pulse is applied to a released block. The reset becomes active at the edge after the `GLITCH_CYC`-th sampled active cycle and lasts exactly `TIMEOUT_CYC` cycles.
- R6: An external active level lasting fewer than `GLITCH_CYC` consecutive sampled cycles has no effect, and `reset_active` stays 0.
- R7: `wdog_req` = 1, sampled while the reset is released, makes the reset active at the next edge for exactly `TIMEOUT_CYC` cycles.
- R8: `wdog_req` = 1, sampled while the timeout is running, restarts the timeout. The reset stays active for exactly `TIMEOUT_CYC` cycles from that edge.
- R9: The block's own drive is masked from its sense inputs. The reset does not reassert by itself after release, even though the pins read active throughout the hold.
- R10: While `rst_n` is 0, the sequencer is in the supply-low state with `reset_active` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low logic reset |
| supply_ok | input | 1 | Synchronized comparator flag, 1 = supply at or above threshold |
| rst_hi_sense | input | 1 | Level read back from the active-high reset pin |
| rst_lo_sense_n | input | 1 | Level read back from the active-low reset pin |
| wdog_req | input | 1 | Watchdog timeout request, 1 = start a reset |
| rst_hi_drive | output | 1 | 1 = drive the active-high pin high, 0 = release to pull-down |
| rst_lo_drive | output | 1 | 1 = drive the active-low pin low, 0 = release to pull-up |
| reset_active | output | 1 | 1 while the block holds the system in reset |

## Verification
The bench drives external pulses of random lengths on a randomly chosen pin. The lengths fall on both sides of the glitch length, and a pulse exactly at that length shows where rejection ends and qualification begins. Pulses longer than the glitch length check that the timeout is counted from qualification rather than from release. Watchdog requests are tried from the released state and in the middle of a running timeout, which separates a fresh start from a restart. Supply drops are tried while released and during a hold, which separates the brownout path from the power-up path. Idle gaps after every release show whether the pins, which read active all through the hold, can retrigger the block.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_HOLD       = 2'd1,
        ST_RUN        = 2'd2
    } rsq_state_e;
endpackage

// File: rtl/rsq_glitch_filter.sv
module rsq_glitch_filter #(
    parameter int unsigned GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic qualified
);
    localparam int unsigned CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(GLITCH_CYC);

    logic [CW-1:0] run_q;

    // Count consecutive active samples, saturating at the glitch length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!level_in) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qualified = (run_q == RUN_MAX);
endmodule

// File: rtl/rsq_hold_timer.sv
module rsq_hold_timer #(
    parameter int unsigned TIMEOUT_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer
    import rsq_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 2000,
    parameter int unsigned GLITCH_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic rst_hi_sense,
    input  logic rst_lo_sense_n,
    input  logic wdog_req,
    output logic rst_hi_drive,
    output logic rst_lo_drive,
    output logic reset_active
);
    localparam int unsigned NUM_PINS = 2;

    rsq_state_e state_q, state_d;
    logic driving;
    logic timer_clear, timer_expired;
    logic ext_cause;
    logic [NUM_PINS-1:0] pin_active, pin_masked, pin_qual;

    // Normalize both pins to "1 = active", then hide the block's own drive.
    assign pin_active = {rst_hi_sense, ~rst_lo_sense_n};
    assign pin_masked = pin_active & {NUM_PINS{~driving}};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        rsq_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_in  (pin_masked[p]),
            .qualified (pin_qual[p])
        );
    end

    assign ext_cause = |pin_qual;

    // Timer runs only in HOLD; a watchdog request restarts it.
    assign timer_clear = (state_q != ST_HOLD) || wdog_req;

    rsq_hold_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .expired (timer_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SUPPLY_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPPLY_LOW: begin
                if (supply_ok) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!supply_ok) state_d = ST_SUPPLY_LOW;
                else if (timer_expired && !wdog_req) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!supply_ok) state_d = ST_SUPPLY_LOW;
                else if (wdog_req || ext_cause) state_d = ST_HOLD;
            end
            default: state_d = ST_SUPPLY_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  driving = 1'b0;
            default: driving = 1'b1;
        endcase
        rst_hi_drive = driving;
        rst_lo_drive = driving;
        reset_active = driving;
    end
endmodule

// File: rtl/supply_reset_sequencer_chk.sv
module supply_reset_sequencer_chk #(
    parameter int unsigned TIMEOUT_CYC = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic wdog_req,
    input logic rst_hi_drive,
    input logic rst_lo_drive,
    input logic reset_active
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] HELD_MAX = CW'(TIMEOUT_CYC);

    logic [CW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (!reset_active) begin
            held_q <= '0;
        end else if (held_q != HELD_MAX) begin
            held_q <= held_q + 1'b1;
        end
    end

    a_r1_low_supply_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (reset_active && rst_hi_drive && rst_lo_drive));

    a_r7_wdog_starts: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |=> reset_active);

    a_r9_no_self_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reset_active) && supply_ok && !wdog_req) |=> !reset_active);

    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_active) |-> (held_q == HELD_MAX));
endmodule

bind supply_reset_sequencer supply_reset_sequencer_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .wdog_req     (wdog_req),
    .rst_hi_drive (rst_hi_drive),
    .rst_lo_drive (rst_lo_drive),
    .reset_active (reset_active)
);

// File: tb/supply_reset_sequencer_tb.sv
module supply_reset_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T = 40;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic wdog_req = 1'b0;
    logic ext_hi_force = 1'b0;
    logic ext_lo_force = 1'b0;
    logic rst_hi_sense, rst_lo_sense_n;
    logic rst_hi_drive, rst_lo_drive, reset_active;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Pin model: driven level or external force wins over the pull device.
    assign rst_hi_sense   = rst_hi_drive | ext_hi_force;
    assign rst_lo_sense_n = ~(rst_lo_drive | ext_lo_force);

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_reset_sequencer #(.TIMEOUT_CYC(T), .GLITCH_CYC(G)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .rst_hi_sense   (rst_hi_sense),
        .rst_lo_sense_n (rst_lo_sense_n),
        .wdog_req       (wdog_req),
        .rst_hi_drive   (rst_hi_drive),
        .rst_lo_drive   (rst_lo_drive),
        .reset_active   (reset_active)
    );

    function automatic int exp_ext(int len);
        return (len >= G) ? (G + T - len) : 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic count_active(input bit include_now, output int n);
        n = 0;
        if (include_now) begin
            if (!reset_active) return;
            n = 1;
        end
        for (int i = 0; i < T + 20; i++) begin
            @(negedge clk);
            if (reset_active) n++;
            else break;
        end
    endtask

    task automatic check_released_gap(string tag);
        int gap;
        int seen;
        chk(!rst_hi_drive && !rst_lo_drive, {tag, " R4 released drives"},
            {rst_hi_drive, rst_lo_drive}, 0);
        gap = 2 + int'($urandom % 5);
        seen = 0;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            if (reset_active) seen++;
        end
        chk(seen == 0, {tag, " R9 no self retrigger"}, seen, 0);
    endtask

    task automatic ext_pulse(bit on_hi, int len, string tag);
        int n;
        if (on_hi) ext_hi_force = 1'b1;
        else ext_lo_force = 1'b1;
        repeat (len) @(negedge clk);
        ext_hi_force = 1'b0;
        ext_lo_force = 1'b0;
        count_active(1'b0, n);
        chk(n == exp_ext(len), tag, n, exp_ext(len));
        check_released_gap(tag);
    endtask

    task automatic wdog_pulse();
        wdog_req = 1'b1;
        @(negedge clk);
        wdog_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(reset_active && rst_hi_drive && rst_lo_drive, "R10 active in reset",
            reset_active, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(reset_active && rst_hi_drive && rst_lo_drive, "R1 low supply after reset",
            reset_active, 1);

        // R2 power-up hold
        supply_ok = 1'b1;
        count_active(1'b0, n);
        chk(n == T, "R2 power-up hold length", n, T);
        check_released_gap("R2");

        // R3 brownout while released, then R1 held, then R2 again
        supply_ok = 1'b0;
        @(negedge clk);
        chk(reset_active == 1'b1, "R3 brownout next edge", reset_active, 1);
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (reset_active && rst_hi_drive && rst_lo_drive) n++;
        end
        chk(n == 6, "R1 held during low supply", n, 6);
        supply_ok = 1'b1;
        count_active(1'b0, n);
        chk(n == T, "R2 hold after brownout", n, T);
        check_released_gap("R3");

        // R6 glitches on each pin, R5 exact length on each pin
        ext_pulse(1'b1, G - 1, "R6 glitch on high pin");
        ext_pulse(1'b0, G - 1, "R6 glitch on low pin");
        ext_pulse(1'b1, G, "R5 exact length high pin");
        ext_pulse(1'b0, G, "R5 exact length low pin");
        ext_pulse(1'b0, 2 * G, "R5 long pulse low pin");

        // R7 watchdog from released state
        wdog_pulse();
        count_active(1'b1, n);
        chk(n == T, "R7 watchdog hold length", n, T);
        check_released_gap("R7");

        // R8 restart in the middle of a hold
        wdog_pulse();
        repeat (T / 2) @(negedge clk);
        chk(reset_active == 1'b1, "R8 still holding before restart", reset_active, 1);
        wdog_pulse();
        count_active(1'b1, n);
        chk(n == T, "R8 restart hold length", n, T);
        check_released_gap("R8");

        // Supply drop during hold returns to the supply-low path
        wdog_pulse();
        repeat (5) @(negedge clk);
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk(reset_active == 1'b1, "R1 supply drop during hold", reset_active, 1);
        supply_ok = 1'b1;
        count_active(1'b0, n);
        chk(n == T, "R2 hold after drop during hold", n, T);
        check_released_gap("R2 drop");

        // Random mix of causes
        for (int it = 0; it < 30; it++) begin
            int kind;
            int len;
            kind = int'($urandom % 3);
            len = 1 + int'($urandom % (2 * G));
            if (kind == 2) begin
                wdog_pulse();
                count_active(1'b1, n);
                chk(n == T, "R7 random watchdog", n, T);
                check_released_gap("R7 random");
            end else if (len >= G) begin
                ext_pulse(kind == 1, len, "R5 random pulse");
            end else begin
                ext_pulse(kind == 1, len, "R6 random glitch");
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule